// File: doc/BRIEF.md
# Passcode-Gated Interrupt Register Bank

This block is the interrupt and write-protection register slave of a fuse controller. It sits behind a simple valid/write/address/data port carrying whole 32-bit words. It keeps a lock that refuses every register write except to the lock word itself until software presents a 16-bit passcode. It also keeps a sticky interrupt status word, an interrupt mask, and two write-only command words that clear or set mask bits. A single level interrupt output is raised while any unmasked status bit is set.

Interrupt sources elsewhere in the controller raise status bits with single-cycle pulses on a 32-bit event input. Only software clears a status bit, by writing a one to it. The mask cannot be written directly. Software unmasks sources through the enable word and masks them through the disable word.

The lock is a two-state machine. `LK_LOCKED` is the reset state. Transition `UNLOCK` goes to `LK_OPEN` on a lock-word write of the passcode. Transition `RELOCK` returns to `LK_LOCKED` on a lock-word write of any other value. A lock-word write of the passcode while open stays open (`KEEP_OPEN`). A lock-word write of any other value while locked stays locked (`KEEP_LOCKED`). With no lock-word write, the state holds.

Top module: `fuse_irq_regbank`

## Requirements
- R1: After reset the lock word (offset 0x00) reads 1, status (0x30) reads 0, mask (0x34) reads 0x80007FFF and the interrupt output is low.
- R2: A write to offset 0x00 of exactly 0x0000DF0D makes the lock word read 0. A write of any other 32-bit value makes it read 1. Lock-word writes are accepted in both states.
- R3: While the lock word reads 1, writes to every offset other than 0x00 leave all register contents unchanged.
- R4: Only status and mask bits 0 to 14 and bit 31 exist. Bits 15 to 30 always read 0 and events on them are ignored.
- R5: Status bits are write-one-to-clear at 0x30. A one on bit n of the event input sets status bit n at the next clock edge. Hardware never clears a status bit. A same-cycle event and software clear of one bit leave it set.
- R6: The mask word at 0x34 is read-only, so writes to it have no effect.
- R7: Writing ones to 0x38 clears the matching mask bits, and writing ones to 0x3C sets them. Both offsets read 0.
- R8: The interrupt output equals the OR of (status AND NOT mask). It is registered and lags a status or mask change by one clock cycle.
- R9: Reads of unmapped offsets (such as 0x04, 0x44, 0xFC) return 0, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_valid | input | 1 | Access strobe, one cycle per access |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset of the word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| evt_set | input | 32 | Single-cycle status set pulses, one per source bit |
| irq | output | 1 | Level interrupt |

## Verification
Register writes and event pulses take effect at the clock edge on which they are presented. The bench reads back at the following falling edge, because read data is combinational on the address. The interrupt output is due one edge later than the status or mask change that causes it. After each event or command write, the bench checks that the interrupt output still holds its old value at the first falling edge, and checks for the new value at the next falling edge. The bench sweeps every source bit through the unmask, event, mask, unmask and clear sequence, and compares each result with a software mirror of status and mask.

// File: rtl/fuse_irq_pkg.sv
package fuse_irq_pkg;
    localparam int unsigned WORD_W = 32;
    localparam logic [WORD_W-1:0] SRC_BITS   = 32'h8000_7FFF;
    localparam logic [WORD_W-1:0] PASS_CODE  = 32'h0000_DF0D;
    localparam logic [7:0] OFS_LOCK = 8'h00;
    localparam logic [7:0] OFS_STAT = 8'h30;
    localparam logic [7:0] OFS_MASK = 8'h34;
    localparam logic [7:0] OFS_EN   = 8'h38;
    localparam logic [7:0] OFS_DIS  = 8'h3C;

    typedef enum logic {
        LK_LOCKED = 1'b0,
        LK_OPEN   = 1'b1
    } lock_state_e;
endpackage

// File: rtl/fuse_lock_fsm.sv
module fuse_lock_fsm
    import fuse_irq_pkg::*;
#(
    parameter int unsigned DATA_W = WORD_W,
    parameter logic [DATA_W-1:0] KEY = PASS_CODE
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lock_wr,
    input  logic [DATA_W-1:0] wdata,
    output logic              locked
);
    lock_state_e state_q, state_d;
    logic key_ok;

    assign key_ok = (wdata == KEY);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= LK_LOCKED;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LK_LOCKED: if (lock_wr && key_ok)  state_d = LK_OPEN;
            LK_OPEN:   if (lock_wr && !key_ok) state_d = LK_LOCKED;
            default:   state_d = LK_LOCKED;
        endcase
    end

    always_comb begin
        locked = (state_q != LK_OPEN);
    end

    // R2
    key_opens_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lock_wr && wdata == KEY) |=> !locked);
    // R2
    bad_key_locks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lock_wr && wdata != KEY) |=> locked);
    // R2
    lock_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !lock_wr |=> $stable(locked));
endmodule

// File: rtl/fuse_irq_core.sv
module fuse_irq_core
    import fuse_irq_pkg::*;
#(
    parameter int unsigned DATA_W = WORD_W,
    parameter logic [DATA_W-1:0] SRC_MASK = SRC_BITS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] evt_set,
    input  logic              stat_clr_wr,
    input  logic              en_wr,
    input  logic              dis_wr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] status,
    output logic [DATA_W-1:0] mask,
    output logic              irq
);
    logic [DATA_W-1:0] set_v, clr_v, status_d, mask_d;

    always_comb begin
        set_v    = evt_set & SRC_MASK;
        clr_v    = stat_clr_wr ? (wdata & SRC_MASK) : '0;
        status_d = (status & ~clr_v) | set_v;
        mask_d   = mask;
        if (en_wr)  mask_d = mask & ~(wdata & SRC_MASK);
        if (dis_wr) mask_d = mask | (wdata & SRC_MASK);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            status <= '0;
            mask   <= SRC_MASK;
            irq    <= 1'b0;
        end else begin
            status <= status_d;
            mask   <= mask_d;
            irq    <= |(status & ~mask);
        end
    end

    // R5
    evt_sticks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((evt_set & SRC_MASK) != '0) |=>
        ((status & $past(evt_set & SRC_MASK)) == $past(evt_set & SRC_MASK)));
    // R5
    no_hw_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !stat_clr_wr |=> ((status & $past(status)) == $past(status)));
    // R6
    mask_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_wr && !dis_wr) |=> $stable(mask));
    // R4
    rsvd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((status & ~SRC_MASK) == '0) && ((mask & ~SRC_MASK) == '0));
    // R8
    all_masked_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(mask) == SRC_MASK) |-> !irq);
endmodule

// File: rtl/fuse_rd_mux.sv
module fuse_rd_mux
    import fuse_irq_pkg::*;
#(
    parameter int unsigned ADDR_W = 8,
    parameter int unsigned DATA_W = WORD_W
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              locked,
    input  logic [DATA_W-1:0] status,
    input  logic [DATA_W-1:0] mask,
    output logic [DATA_W-1:0] rdata
);
    always_comb begin
        rdata = '0;
        if (addr == ADDR_W'(OFS_LOCK))      rdata = DATA_W'(locked);
        else if (addr == ADDR_W'(OFS_STAT)) rdata = status;
        else if (addr == ADDR_W'(OFS_MASK)) rdata = mask;
    end
endmodule

// File: rtl/fuse_irq_regbank.sv
module fuse_irq_regbank
    import fuse_irq_pkg::*;
#(
    parameter int unsigned ADDR_W = 8,
    parameter logic [WORD_W-1:0] SRC_MASK = SRC_BITS,
    parameter logic [WORD_W-1:0] KEY = PASS_CODE
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_valid,
    input  logic              bus_write,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [WORD_W-1:0] bus_wdata,
    output logic [WORD_W-1:0] bus_rdata,
    input  logic [WORD_W-1:0] evt_set,
    output logic              irq
);
    localparam logic [ADDR_W-1:0] A_LOCK = ADDR_W'(OFS_LOCK);
    localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(OFS_STAT);
    localparam logic [ADDR_W-1:0] A_EN   = ADDR_W'(OFS_EN);
    localparam logic [ADDR_W-1:0] A_DIS  = ADDR_W'(OFS_DIS);

    logic wr, locked, open_wr;
    logic lock_wr, stat_clr_wr, en_wr, dis_wr;
    logic [WORD_W-1:0] status, mask;

    assign wr          = bus_valid && bus_write;
    assign lock_wr     = wr && (bus_addr == A_LOCK);
    assign open_wr     = wr && !locked;
    assign stat_clr_wr = open_wr && (bus_addr == A_STAT);
    assign en_wr       = open_wr && (bus_addr == A_EN);
    assign dis_wr      = open_wr && (bus_addr == A_DIS);

    fuse_lock_fsm #(.DATA_W(WORD_W), .KEY(KEY)) u_lock (
        .clk(clk), .rst_n(rst_n), .lock_wr(lock_wr),
        .wdata(bus_wdata), .locked(locked)
    );

    fuse_irq_core #(.DATA_W(WORD_W), .SRC_MASK(SRC_MASK)) u_core (
        .clk(clk), .rst_n(rst_n), .evt_set(evt_set),
        .stat_clr_wr(stat_clr_wr), .en_wr(en_wr), .dis_wr(dis_wr),
        .wdata(bus_wdata), .status(status), .mask(mask), .irq(irq)
    );

    fuse_rd_mux #(.ADDR_W(ADDR_W), .DATA_W(WORD_W)) u_rd (
        .addr(bus_addr), .locked(locked), .status(status),
        .mask(mask), .rdata(bus_rdata)
    );

    // R3
    locked_mask_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && locked && bus_addr != A_LOCK) |=> $stable(mask));
    // R3
    locked_stat_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && locked && bus_addr != A_LOCK) |=>
        ((status & $past(status)) == $past(status)));
endmodule

// File: tb/fuse_irq_regbank_bench.sv
`timescale 1ns/1ps
module fuse_irq_regbank_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_valid = 1'b0;
    logic        bus_write = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [31:0] evt_set = '0;
    logic        irq;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;
    logic [31:0] exp_status = '0;
    logic [31:0] exp_mask = 32'h8000_7FFF;
    localparam logic [31:0] VALID = 32'h8000_7FFF;

    always #2 clk = ~clk;

    fuse_irq_regbank u_fuse_irq_regbank (
        .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .evt_set(evt_set), .irq(irq)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_valid = 1'b0; bus_write = 1'b0;
    endtask

    task automatic bus_rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic pulse(input logic [31:0] v);
        @(negedge clk);
        evt_set = v;
        @(negedge clk);
        evt_set = '0;
    endtask

    task automatic rd_chk(input string tag, input logic [7:0] a, input logic [31:0] exp);
        logic [31:0] d;
        bus_rd(a, d);
        chk(tag, d, exp);
    endtask

    function automatic logic exp_irq();
        return |(exp_status & ~exp_mask);
    endfunction

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        rd_chk("R1 lock reset", 8'h00, 32'd1);
        rd_chk("R1 status reset", 8'h30, 32'h0);
        rd_chk("R1 mask reset", 8'h34, 32'h8000_7FFF);
        chk("R1 irq reset", {31'b0, irq}, 32'd0);

        // R3 writes refused while locked
        bus_wr(8'h38, 32'hFFFF_FFFF);
        rd_chk("R3 enable dropped", 8'h34, exp_mask);
        pulse(32'h0000_0008); exp_status = 32'h8;
        bus_wr(8'h30, 32'hFFFF_FFFF);
        rd_chk("R3 clear dropped", 8'h30, exp_status);

        // R2 passcode handling
        bus_wr(8'h00, 32'h0000_DF0C);
        rd_chk("R2 near key", 8'h00, 32'd1);
        bus_wr(8'h00, 32'h0001_DF0D);
        rd_chk("R2 upper bits", 8'h00, 32'd1);
        bus_wr(8'h00, 32'h0000_DF0D);
        rd_chk("R2 key opens", 8'h00, 32'd0);
        bus_wr(8'h00, 32'h0000_DF0D);
        rd_chk("R2 key keeps open", 8'h00, 32'd0);

        bus_wr(8'h30, 32'hFFFF_FFFF); exp_status = '0;
        rd_chk("R5 w1c all", 8'h30, 32'h0);

        // R5 R7 R8 sweep over every source bit
        for (int k = 0; k < 16; k++) begin
            int b;
            logic [31:0] bit_v;
            b = (k == 15) ? 31 : k;
            bit_v = 32'h1 << b;
            bus_wr(8'h38, bit_v); exp_mask &= ~bit_v;
            rd_chk($sformatf("R7 enable bit %0d", b), 8'h34, exp_mask);
            pulse(bit_v); exp_status |= bit_v;
            chk($sformatf("R8 irq lag bit %0d", b), {31'b0, irq}, 32'd0);
            @(negedge clk);
            chk($sformatf("R8 irq raise bit %0d", b), {31'b0, irq}, {31'b0, exp_irq()});
            rd_chk($sformatf("R5 set bit %0d", b), 8'h30, exp_status);
            bus_wr(8'h3C, bit_v); exp_mask |= bit_v;
            chk($sformatf("R8 mask lag bit %0d", b), {31'b0, irq}, 32'd1);
            @(negedge clk);
            chk($sformatf("R8 mask drop bit %0d", b), {31'b0, irq}, {31'b0, exp_irq()});
            rd_chk($sformatf("R7 disable bit %0d", b), 8'h34, exp_mask);
            bus_wr(8'h38, bit_v); exp_mask &= ~bit_v;
            @(negedge clk);
            chk($sformatf("R8 unmask bit %0d", b), {31'b0, irq}, {31'b0, exp_irq()});
            bus_wr(8'h30, bit_v); exp_status &= ~bit_v;
            @(negedge clk);
            chk($sformatf("R8 clear bit %0d", b), {31'b0, irq}, 32'd0);
            rd_chk($sformatf("R5 w1c bit %0d", b), 8'h30, exp_status);
        end

        // R4 reserved bits
        pulse(32'h7FFF_8000);
        rd_chk("R4 reserved events", 8'h30, 32'h0);
        bus_wr(8'h3C, 32'hFFFF_FFFF); exp_mask = VALID;
        rd_chk("R4 mask reserved zero", 8'h34, VALID);
        // R7 command words read 0
        rd_chk("R7 enable reads 0", 8'h38, 32'h0);
        rd_chk("R7 disable reads 0", 8'h3C, 32'h0);
        // R6 mask read-only
        bus_wr(8'h34, 32'h1234_5678);
        rd_chk("R6 mask write ignored", 8'h34, VALID);

        // R5 same-cycle set and clear
        pulse(32'h20); exp_status = 32'h20;
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b1; bus_addr = 8'h30;
        bus_wdata = 32'h0000_0021; evt_set = 32'h21;
        @(negedge clk);
        bus_valid = 1'b0; bus_write = 1'b0; evt_set = '0;
        exp_status = 32'h21;
        rd_chk("R5 set wins", 8'h30, exp_status);

        // R9 unmapped offsets
        bus_wr(8'h04, 32'hFFFF_FFFF);
        rd_chk("R9 read 0x04", 8'h04, 32'h0);
        rd_chk("R9 read 0x44", 8'h44, 32'h0);
        rd_chk("R9 read 0xFC", 8'h FC, 32'h0);
        rd_chk("R9 status intact", 8'h30, exp_status);
        rd_chk("R9 mask intact", 8'h34, exp_mask);

        // R2 relock then R3 drop
        bus_wr(8'h00, 32'h0);
        rd_chk("R2 relock", 8'h00, 32'd1);
        bus_wr(8'h38, 32'hFFFF_FFFF);
        rd_chk("R3 enable dropped relocked", 8'h34, exp_mask);
        @(negedge clk);
        chk("R3 irq stays low", {31'b0, irq}, 32'd0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual running expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule